// File: doc/BRIEF.md
# Serial Capture/Update Register Pair for Image Selection

This block is the serial-access register pair of a configuration-image upgrade controller. A 39-bit shift register with two extra mode bits is loaded and read one bit per clock through `din` and `dout`. A 39-bit update register holds the settings that are in force. Two control inputs choose the operation that every rising clock edge performs. The edge either shifts the data field, copies it into the update register, or captures a new value into it.

During a capture, the two mode bits pick the source. The choices are the live state word, one of two 31-bit history records widened with eight leading zeros, or the update register itself. Capturing the update register and shifting it out reads back the settings that are in force. The update register keeps only its low 14 bits. Bit 12 is an override enable. When it is set, bit 13 replaces the external select pin as the effective image select.

Top module: `cfg_upgrade_regs`

## Requirements
- R1: While `rst_n` is low, the shift data, the mode bits and the update register are cleared. After reset, `dout` is 0, a readback of the shift data gives 0, and `eff_sel` follows `cfg_sel_pin`.
- R2: With `shift_nld`=1, every rising edge moves the data field one place toward bit 0 and loads `din` into bit 38. `dout` always shows bit 0, so a word shifted in bit 0 first reads back unchanged, whatever `capt_nupdt` does.
- R3: With `shift_nld`=0 and `capt_nupdt`=0, a rising edge copies shift bits 13:0 into the update register.
- R4: With `shift_nld`=0 and `capt_nupdt`=1, a rising edge captures into the data field. Mode 00 selects the 39-bit `cur_state` input.
- R5: Mode 01 captures `prev_a` and mode 10 captures `prev_b`. Each is 31 bits wide and is placed in bits 30:0, with bits 38:31 zero.
- R6: Mode 11 captures the update register's contents.
- R7: Update register bits 38:14 always read back as 0, whatever was shifted in.
- R8: `eff_sel` equals update bit 13 when update bit 12 is 1. It equals `cfg_sel_pin` when update bit 12 is 0.
- R9: The mode bits change only on a rising edge with `mode_load`=1, which loads them from `mode_in`. Shifting, updating and capturing leave them unchanged.
- R10: A shift or a capture leaves the update register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_nld | input | 1 | 1 = shift, 0 = update or capture |
| capt_nupdt | input | 1 | When not shifting: 1 = capture, 0 = update |
| din | input | 1 | Serial data in, enters at bit 38 |
| dout | output | 1 | Serial data out, shift bit 0 |
| mode_load | input | 1 | Strobe that writes the mode bits |
| mode_in | input | 2 | New mode bit value |
| cur_state | input | 39 | Live state word, capture source 00 |
| prev_a | input | 31 | First history record, capture source 01 |
| prev_b | input | 31 | Second history record, capture source 10 |
| cfg_sel_pin | input | 1 | External image select |
| eff_sel | output | 1 | Effective image select |

## Verification
The assertions assume that the capture sources, the select pin and the control inputs are stable around each rising edge, because each property compares a register with the value its source had one edge earlier. The bench changes every input only at falling edges. It sweeps all four capture modes over several source patterns, and it sweeps all eight combinations of the override bit, the select bit and the pin. This keeps every `$past` comparison well defined. Mode loads are always paired with a capture edge, so the capture that edge performs uses the previous mode, as the properties expect.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  typedef enum logic [1:0] {
    SRC_CURRENT = 2'b00,
    SRC_PREV_A  = 2'b01,
    SRC_PREV_B  = 2'b10,
    SRC_UPDATE  = 2'b11
  } cap_src_e;

  typedef enum logic [1:0] {
    OP_UPDATE  = 2'b00,
    OP_CAPTURE = 2'b01,
    OP_SHIFT   = 2'b10
  } op_e;

  function automatic op_e decode_op(input logic shift_nld, input logic capt_nupdt);
    if (shift_nld)       return OP_SHIFT;
    else if (capt_nupdt) return OP_CAPTURE;
    else                 return OP_UPDATE;
  endfunction

endpackage

// File: rtl/cfg_capture_mux.sv
module cfg_capture_mux
  import cfgreg_pkg::*;
#(
  parameter int DATA_W = 39,
  parameter int PREV_W = 31
) (
  input  cap_src_e            src,
  input  logic [DATA_W-1:0]   cur_state,
  input  logic [PREV_W-1:0]   prev_a,
  input  logic [PREV_W-1:0]   prev_b,
  input  logic [DATA_W-1:0]   upd_val,
  output logic [DATA_W-1:0]   cap_val
);

  localparam int PAD_W = DATA_W - PREV_W;

  logic [DATA_W-1:0] prev_a_ext;
  logic [DATA_W-1:0] prev_b_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign prev_a_ext = {{PAD_W{1'b0}}, prev_a};
      assign prev_b_ext = {{PAD_W{1'b0}}, prev_b};
    end else begin : g_nopad
      assign prev_a_ext = prev_a[DATA_W-1:0];
      assign prev_b_ext = prev_b[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_CURRENT: cap_val = cur_state;
      SRC_PREV_A:  cap_val = prev_a_ext;
      SRC_PREV_B:  cap_val = prev_b_ext;
      default:     cap_val = upd_val;
    endcase
  end

endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain
  import cfgreg_pkg::*;
#(
  parameter int DATA_W = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sh_en,
  input  logic              cap_en,
  input  logic              din,
  input  logic [DATA_W-1:0] cap_val,
  input  logic              mode_load,
  input  logic [1:0]        mode_in,
  output logic [DATA_W-1:0] sh_q,
  output cap_src_e          mode_q
);

  logic [DATA_W-1:0] sh_d;
  cap_src_e          mode_d;
  logic              sh_ce;

  // next-state logic
  always_comb begin
    sh_ce = sh_en | cap_en;
    if (sh_en) sh_d = {din, sh_q[DATA_W-1:1]};
    else       sh_d = cap_val;
    mode_d = cap_src_e'(mode_in);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_ce) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= SRC_CURRENT;
    else if (mode_load) mode_q <= mode_d;
  end

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> (sh_q[DATA_W-2:0] == $past(sh_q[DATA_W-1:1])) && (sh_q[DATA_W-1] == $past(din))); // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(mode_q)); // R9

endmodule

// File: rtl/cfg_update_reg.sv
module cfg_update_reg #(
  parameter int DATA_W  = 39,
  parameter int SEL_BIT = 13,
  parameter int OVR_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] sh_val,
  input  logic              cfg_sel_pin,
  output logic [DATA_W-1:0] upd_q,
  output logic              eff_sel
);

  localparam int KEEP_W = SEL_BIT + 1;
  localparam logic [DATA_W-1:0] KEEP_MASK = {{(DATA_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};

  logic [DATA_W-1:0] upd_d;

  always_comb begin
    upd_d   = sh_val & KEEP_MASK;
    eff_sel = upd_q[OVR_BIT] ? upd_q[SEL_BIT] : cfg_sel_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_q <= '0;
    else if (upd_en) upd_q <= upd_d;
  end

  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(upd_q)); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (upd_q[DATA_W-1:KEEP_W] == '0)); // R7

endmodule

// File: rtl/cfg_upgrade_regs.sv
module cfg_upgrade_regs
  import cfgreg_pkg::*;
#(
  parameter int DATA_W  = 39,
  parameter int PREV_W  = 31,
  parameter int SEL_BIT = 13,
  parameter int OVR_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_nld,
  input  logic              capt_nupdt,
  input  logic              din,
  output logic              dout,
  input  logic              mode_load,
  input  logic [1:0]        mode_in,
  input  logic [DATA_W-1:0] cur_state,
  input  logic [PREV_W-1:0] prev_a,
  input  logic [PREV_W-1:0] prev_b,
  input  logic              cfg_sel_pin,
  output logic              eff_sel
);

  op_e               op;
  logic              sh_en;
  logic              cap_en;
  logic              upd_en;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] upd_q;
  logic [DATA_W-1:0] cap_val;
  cap_src_e          mode_q;

  always_comb begin
    op     = decode_op(shift_nld, capt_nupdt);
    sh_en  = (op == OP_SHIFT);
    cap_en = (op == OP_CAPTURE);
    upd_en = (op == OP_UPDATE);
  end

  cfg_capture_mux #(.DATA_W(DATA_W), .PREV_W(PREV_W)) u_mux (
    .src       (mode_q),
    .cur_state (cur_state),
    .prev_a    (prev_a),
    .prev_b    (prev_b),
    .upd_val   (upd_q),
    .cap_val   (cap_val)
  );

  cfg_shift_chain #(.DATA_W(DATA_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_en     (sh_en),
    .cap_en    (cap_en),
    .din       (din),
    .cap_val   (cap_val),
    .mode_load (mode_load),
    .mode_in   (mode_in),
    .sh_q      (sh_q),
    .mode_q    (mode_q)
  );

  cfg_update_reg #(.DATA_W(DATA_W), .SEL_BIT(SEL_BIT), .OVR_BIT(OVR_BIT)) u_upd (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (upd_en),
    .sh_val      (sh_q),
    .cfg_sel_pin (cfg_sel_pin),
    .upd_q       (upd_q),
    .eff_sel     (eff_sel)
  );

  assign dout = sh_q[0];

  AST_UPD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (upd_q[SEL_BIT:0] == $past(sh_q[SEL_BIT:0]))); // R3

  AST_CAP_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && mode_q == SRC_CURRENT) |=> (sh_q == $past(cur_state))); // R4

  AST_CAP_PREV_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && (mode_q == SRC_PREV_A || mode_q == SRC_PREV_B)) |=> (sh_q[DATA_W-1:PREV_W] == '0)); // R5

  AST_CAP_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && mode_q == SRC_UPDATE) |=> (sh_q == $past(upd_q))); // R6

endmodule

// File: tb/tb_cfg_upgrade_regs.sv
module tb_cfg_upgrade_regs;
  localparam int DW = 39;
  localparam int PW = 31;
  localparam logic [DW-1:0] KEEP = 39'h3FFF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, shift_nld, capt_nupdt, din, dout, mode_load, cfg_sel_pin, eff_sel;
  logic [1:0]    mode_in;
  logic [DW-1:0] cur_state;
  logic [PW-1:0] prev_a, prev_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_upd;
  logic [DW-1:0] got;
  logic [DW-1:0] w;

  cfg_upgrade_regs dut (
    .clk(clk), .rst_n(rst_n), .shift_nld(shift_nld), .capt_nupdt(capt_nupdt),
    .din(din), .dout(dout), .mode_load(mode_load), .mode_in(mode_in),
    .cur_state(cur_state), .prev_a(prev_a), .prev_b(prev_b),
    .cfg_sel_pin(cfg_sel_pin), .eff_sel(eff_sel)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation, then wait for the falling edge after it took effect
  task automatic step(input logic sn, input logic cu, input logic d,
                      input logic ml = 1'b0, input logic [1:0] mi = 2'b00);
    shift_nld = sn; capt_nupdt = cu; din = d; mode_load = ml; mode_in = mi;
    @(negedge clk);
  endtask

  task automatic load_word(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) step(1'b1, i[0], v[i]);
  endtask

  task automatic read_word(output logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) begin
      v[i] = dout;
      step(1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    step(1'b0, 1'b1, 1'b0, 1'b1, m);
  endtask

  task automatic read_upd(output logic [DW-1:0] v);
    set_mode(2'b11);
    step(1'b0, 1'b1, 1'b0);
    read_word(v);
  endtask

  function automatic logic [DW-1:0] expect_cap(input logic [1:0] m);
    case (m)
      2'b00:   return cur_state;
      2'b01:   return {8'b0, prev_a};
      2'b10:   return {8'b0, prev_b};
      default: return exp_upd;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; shift_nld = 1'b0; capt_nupdt = 1'b0; din = 1'b0;
    mode_load = 1'b0; mode_in = 2'b00; cfg_sel_pin = 1'b0;
    cur_state = '0; prev_a = '0; prev_b = '0; exp_upd = '0;
    shift_nld = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 dout after reset", {38'b0, dout}, '0);
    cfg_sel_pin = 1'b1; #1;
    chk("R1 eff_sel follows pin=1", {38'b0, eff_sel}, {38'b0, 1'b1});
    cfg_sel_pin = 1'b0; #1;
    chk("R1 eff_sel follows pin=0", {38'b0, eff_sel}, '0);
    read_word(got);
    chk("R1 shift data after reset", got, '0);
    read_upd(got);
    chk("R1 update reg after reset", got, '0);

    // R3 R7 R8 sweep of override, select bit and pin
    for (int v = 0; v < 8; v++) begin
      w = {25'h1FF_FFFF ^ 25'(v), v[1], v[0], 12'(12'hA5C + v)};
      load_word(w);
      step(1'b0, 1'b0, 1'b0);
      exp_upd = w & KEEP;
      cfg_sel_pin = v[2]; #1;
      chk("R8 eff_sel", {38'b0, eff_sel}, {38'b0, (v[0] ? v[1] : v[2])});
      cfg_sel_pin = ~v[2]; #1;
      chk("R8 eff_sel pin toggled", {38'b0, eff_sel}, {38'b0, (v[0] ? v[1] : ~v[2])});
      read_upd(got);
      chk("R3 R7 update copy with reserved zero", got, exp_upd);
    end

    // R2 R10 shifting with capt_nupdt toggling keeps update reg, reads back
    cfg_sel_pin = 1'b0;
    w = 39'h12_3456_789A;
    load_word(w);
    #1 chk("R10 eff_sel after shift", {38'b0, eff_sel}, {38'b0, (exp_upd[12] ? exp_upd[13] : 1'b0)});
    read_word(got);
    chk("R2 shift round trip", got, w);
    w = 39'h6D_B6DB_6DB6;
    load_word(w);
    read_word(got);
    chk("R2 shift round trip pattern 2", got, w);
    cur_state = 39'h55_0F0F_00FF;
    set_mode(2'b00);
    step(1'b0, 1'b1, 1'b0);
    read_upd(got);
    chk("R10 update reg kept after capture", got, exp_upd);

    // R9 mode bits survive shifting ones and an update
    prev_a = 31'h7ACE_1234;
    set_mode(2'b01);
    load_word('1);
    step(1'b0, 1'b0, 1'b0);
    exp_upd = '1 & KEEP;
    step(1'b0, 1'b1, 1'b0);
    read_word(got);
    chk("R9 mode kept through shift and update", got, {8'b0, prev_a});

    // R4 R5 R6 capture sweep over modes and source patterns
    for (int k = 0; k < 4; k++) begin
      cur_state = {13{3'(k + 1)}};
      prev_a = {PW{1'b1}} >> k;
      prev_b = 31'(k * 32'h0123_4567 + 5);
      for (int m = 0; m < 4; m++) begin
        set_mode(2'(m));
        step(1'b0, 1'b1, 1'b0);
        read_word(got);
        case (m)
          0: chk("R4 capture current state", got, expect_cap(2'(m)));
          1, 2: chk("R5 capture padded history", got, expect_cap(2'(m)));
          default: chk("R6 capture update reg", got, expect_cap(2'(m)));
        endcase
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule